// File: doc/BRIEF.md
# ADC Threshold Alert Comparator

This block sits beside an analog-to-digital converter and watches the stream of signed conversion results it produces. Each result arrives with a one-cycle valid strobe. The block stores the result in a readable conversion register and compares it against a programmable low threshold and high threshold. When a run of consecutive faulting results reaches the programmed length, it drives an alert pin.

Software sees four 16-bit registers through a plain address / write-enable / read-strobe port. The registers are the conversion result, a configuration word, the low threshold and the high threshold. Results narrower than 16 bits are held left-justified, and every comparison is signed.

Two comparison modes are available:
- Traditional mode trips above the high threshold and releases at or below the low threshold, which gives hysteresis.
- Window mode trips outside the band and releases on the first result inside it.

The alert can be latched until software reads the result, or it can follow the comparison. Its polarity is selectable.

Top module: `alert_thresh_comparator`

## Requirements
- R1: The register addresses are fixed. Address 0 is the conversion result and is read-only. Address 1 is the configuration word, address 2 is the low threshold and address 3 is the high threshold. Writes to address 0 or to any address above 3 change nothing. Reads of addresses above 3 return 0. Read data is combinational from `reg_addr`.
- R2: After reset:
  - configuration reads 0x0003;
  - low threshold reads 0x8000;
  - high threshold reads the most positive left-justified code (0x7FF0 for 12-bit results);
  - conversion register reads 0;
  - the alert pin is inactive (high).
- R3: Each `res_valid` stores `res_data` shifted left by 16-RES_BITS, with zero low bits. The stored value is readable at address 0 from the next cycle.
- R4: Threshold writes store the low 16-RES_BITS bits as zero.
- R5: Configuration bits [1:0] select the queue length. Codes 0, 1 and 2 assert the alert after 1, 2 and 4 consecutive faulting results. The pin changes in the cycle after the strobe that completes the run.
- R6: Queue code 3 disables the comparator. While it is set, the pin is inactive at once, and the alert state and the fault counter are cleared at each clock.
- R7: The fault counter behaves as follows:
  - a non-faulting result clears it;
  - any configuration write clears it;
  - a result that arrives in the same cycle as a configuration write changes neither the counter nor the alert state.
- R8: With bit 4 = 0 (traditional mode), a fault is a result greater than the high threshold. When not latched, the alert releases on a result at or below the low threshold and is otherwise held.
- R9: With bit 4 = 1 (window mode), a fault is a result above the high threshold or below the low threshold. When not latched, the alert releases on the first in-range result.
- R10: With bit 2 = 1 (latched), an asserted alert stays asserted until a read strobe at address 0. With bit 2 = 0, reads have no effect on the alert.
- R11: If a result completes a fault run in the same cycle as a clearing read, the alert is left set.
- R12: Bit 3 selects polarity. A value of 1 makes the pin active-high. A value of 0 makes it active-low, so the inactive pin is high.
- R13: Configuration bits [15:5] are stored and read back unchanged and do not affect the comparator.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | ADDR_W | Register address |
| reg_wr | input | 1 | Write enable for `reg_wdata` at `reg_addr` |
| reg_wdata | input | 16 | Write data |
| reg_rd | input | 1 | Read strobe (clears a latched alert at address 0) |
| reg_rdata | output | 16 | Read data for `reg_addr` |
| res_valid | input | 1 | New conversion result strobe |
| res_data | input | RES_BITS | Signed conversion result |
| alert_pin | output | 1 | Alert output, polarity per configuration |

## Verification
The bench builds the block with RES_BITS = 12 and ADDR_W = 8. With these values the four-bit left justification and the masking of threshold low bits are both active, and unmapped addresses up to 255 can be reached. A randomly chosen configuration covers every queue length, both modes, both polarities and both latch settings. Random thresholds over the full signed range bring result-equals-threshold and inverted-band cases within reach.

// File: rtl/alert_cmp_pkg.sv
package alert_cmp_pkg;
   localparam int unsigned REG_W = 16;
   localparam int unsigned QUEUE_W = 2;
   localparam logic [QUEUE_W-1:0] QUEUE_OFF = '1;

   typedef struct packed {
      logic [10:0]        spare;
      logic               window;
      logic               act_high;
      logic               latch;
      logic [QUEUE_W-1:0] queue;
   } cfg_t;
endpackage

// File: rtl/alert_regs.sv
module alert_regs
   import alert_cmp_pkg::*;
#(
   parameter int unsigned RES_BITS = 12,
   parameter int unsigned ADDR_W   = 8,
   parameter logic [REG_W-1:0] CFG_RST = 16'h0003
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic [ADDR_W-1:0]        reg_addr,
   input  logic                     reg_wr,
   input  logic [REG_W-1:0]         reg_wdata,
   input  logic                     reg_rd,
   output logic [REG_W-1:0]         reg_rdata,
   input  logic                     res_valid,
   input  logic [RES_BITS-1:0]      res_data,
   output logic [REG_W-1:0]         res_just,
   output cfg_t                     cfg,
   output logic [REG_W-1:0]         lo_th,
   output logic [REG_W-1:0]         hi_th,
   output logic [REG_W-1:0]         conv_val,
   output logic                     cfg_wr,
   output logic                     conv_rd
);
   localparam int unsigned PAD = REG_W - RES_BITS;
   localparam logic [ADDR_W-1:0] AD_CONV = ADDR_W'(0);
   localparam logic [ADDR_W-1:0] AD_CFG  = ADDR_W'(1);
   localparam logic [ADDR_W-1:0] AD_LO   = ADDR_W'(2);
   localparam logic [ADDR_W-1:0] AD_HI   = ADDR_W'(3);

   logic [REG_W-1:0] th_mask;

   generate
      if (PAD == 0) begin : g_full
         assign res_just = res_data;
         assign th_mask  = '1;
      end else begin : g_left
         assign res_just = {res_data, {PAD{1'b0}}};
         assign th_mask  = {{RES_BITS{1'b1}}, {PAD{1'b0}}};
      end
   endgenerate

   assign cfg_wr  = reg_wr && (reg_addr == AD_CFG);
   assign conv_rd = reg_rd && (reg_addr == AD_CONV);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg      <= cfg_t'(CFG_RST);
         lo_th    <= 16'h8000;
         hi_th    <= 16'h7FFF & th_mask;
         conv_val <= '0;
      end else begin
         if (cfg_wr) cfg <= cfg_t'(reg_wdata);
         if (reg_wr && reg_addr == AD_LO) lo_th <= reg_wdata & th_mask;
         if (reg_wr && reg_addr == AD_HI) hi_th <= reg_wdata & th_mask;
         if (res_valid) conv_val <= res_just;
      end
   end

   always_comb begin
      unique case (reg_addr)
         AD_CONV: reg_rdata = conv_val;
         AD_CFG:  reg_rdata = cfg;
         AD_LO:   reg_rdata = lo_th;
         AD_HI:   reg_rdata = hi_th;
         default: reg_rdata = '0;
      endcase
   end
endmodule

// File: rtl/alert_fault_q.sv
module alert_fault_q
   import alert_cmp_pkg::*;
#(
   parameter int unsigned CNT_W = 3
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               clr,
   input  logic               sample,
   input  logic               fault,
   input  logic [QUEUE_W-1:0] queue,
   output logic               run_done,
   output logic [CNT_W-1:0]   run_cnt
);
   localparam logic [CNT_W-1:0] MAX_RUN = CNT_W'(1) << (CNT_W - 1);

   logic [CNT_W-1:0] need;
   logic [CNT_W-1:0] inc;

   generate
      if (CNT_W != (1 << QUEUE_W) - 1) begin : g_bad
         $error("alert_fault_q: CNT_W must match the queue field width");
      end
   endgenerate

   assign need     = CNT_W'(1) << queue;
   assign inc      = (run_cnt == MAX_RUN) ? MAX_RUN : run_cnt + CNT_W'(1);
   assign run_done = sample && fault && !clr && (inc >= need);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      run_cnt <= '0;
      else if (clr)    run_cnt <= '0;
      else if (sample) run_cnt <= fault ? inc : '0;
   end
endmodule

// File: rtl/alert_out_stage.sv
module alert_out_stage (
   input  logic clk,
   input  logic rst_n,
   input  logic dis,
   input  logic hold,
   input  logic sample,
   input  logic trip,
   input  logic release_ok,
   input  logic latch,
   input  logic clr_rd,
   input  logic act_high,
   output logic alert_st,
   output logic alert_pin
);
   logic act;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       alert_st <= 1'b0;
      else if (dis)     alert_st <= 1'b0;
      else if (trip)    alert_st <= 1'b1;
      else if (latch) begin
         if (clr_rd)    alert_st <= 1'b0;
      end else if (sample && !hold && release_ok)
                        alert_st <= 1'b0;
   end

   assign act       = alert_st && !dis;
   assign alert_pin = act_high ? act : !act;
endmodule

// File: rtl/alert_thresh_comparator.sv
module alert_thresh_comparator
   import alert_cmp_pkg::*;
#(
   parameter int unsigned RES_BITS = 12,
   parameter int unsigned ADDR_W   = 8,
   parameter logic [15:0] CFG_RST  = 16'h0003
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [ADDR_W-1:0]   reg_addr,
   input  logic                reg_wr,
   input  logic [15:0]         reg_wdata,
   input  logic                reg_rd,
   output logic [15:0]         reg_rdata,
   input  logic                res_valid,
   input  logic [RES_BITS-1:0] res_data,
   output logic                alert_pin
);
   localparam int unsigned CNT_W = (1 << QUEUE_W) - 1;

   generate
      if (RES_BITS < 2 || RES_BITS > REG_W) begin : g_bad_res
         $error("alert_thresh_comparator: RES_BITS out of range");
      end
      if (ADDR_W < 2) begin : g_bad_addr
         $error("alert_thresh_comparator: ADDR_W too small");
      end
   endgenerate

   cfg_t             cfg;
   logic [REG_W-1:0] res_just, lo_th, hi_th, conv_val;
   logic             cfg_wr, conv_rd;
   logic             dis, fault, release_ok, run_done, alert_st;
   logic [CNT_W-1:0] run_cnt;
   logic signed [REG_W-1:0] res_s, lo_s, hi_s;

   alert_regs #(.RES_BITS(RES_BITS), .ADDR_W(ADDR_W), .CFG_RST(CFG_RST)) u_regs (
      .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
      .reg_wdata(reg_wdata), .reg_rd(reg_rd), .reg_rdata(reg_rdata),
      .res_valid(res_valid), .res_data(res_data), .res_just(res_just),
      .cfg(cfg), .lo_th(lo_th), .hi_th(hi_th), .conv_val(conv_val),
      .cfg_wr(cfg_wr), .conv_rd(conv_rd)
   );

   assign res_s = res_just;
   assign lo_s  = lo_th;
   assign hi_s  = hi_th;
   assign dis   = (cfg.queue == QUEUE_OFF);

   always_comb begin
      fault      = (res_s > hi_s) || (cfg.window && (res_s < lo_s));
      release_ok = cfg.window ? !fault : (res_s <= lo_s);
   end

   alert_fault_q #(.CNT_W(CNT_W)) u_queue (
      .clk(clk), .rst_n(rst_n), .clr(cfg_wr || dis), .sample(res_valid),
      .fault(fault), .queue(cfg.queue), .run_done(run_done), .run_cnt(run_cnt)
   );

   alert_out_stage u_out (
      .clk(clk), .rst_n(rst_n), .dis(dis), .hold(cfg_wr), .sample(res_valid),
      .trip(run_done), .release_ok(release_ok), .latch(cfg.latch),
      .clr_rd(conv_rd), .act_high(cfg.act_high), .alert_st(alert_st),
      .alert_pin(alert_pin)
   );
endmodule

// File: rtl/alert_thresh_checker.sv
module alert_thresh_checker #(
   parameter int unsigned RES_BITS = 12,
   parameter int unsigned ADDR_W   = 8
) (
   input logic                clk,
   input logic                rst_n,
   input logic [ADDR_W-1:0]   reg_addr,
   input logic                reg_wr,
   input logic                res_valid,
   input logic [RES_BITS-1:0] res_data,
   input logic [15:0]         conv_val,
   input logic [1:0]          queue,
   input logic                latch,
   input logic                act_high,
   input logic                alert_pin,
   input logic                alert_st,
   input logic [2:0]          run_cnt,
   input logic                run_done,
   input logic                cfg_wr,
   input logic                conv_rd
);
   // R6
   disabled_pin_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (queue == 2'b11) |-> (alert_pin == !act_high));

   // R7
   cnt_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && reg_addr == ADDR_W'(1)) |=> (run_cnt == 3'd0));

   // R3
   conv_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
      res_valid |=> (conv_val[15 -: RES_BITS] == $past(res_data)));

   // R1
   conv_ro_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && reg_addr == ADDR_W'(0) && !res_valid) |=> $stable(conv_val));

   // R10
   latch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (alert_st && latch && !conv_rd && !cfg_wr && queue != 2'b11) |=> alert_st);

   // R5
   cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      run_cnt <= 3'd4);

   // R11
   trip_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      run_done |=> alert_st);
endmodule

bind alert_thresh_comparator alert_thresh_checker #(.RES_BITS(RES_BITS), .ADDR_W(ADDR_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
   .res_valid(res_valid), .res_data(res_data), .conv_val(conv_val),
   .queue(cfg.queue), .latch(cfg.latch), .act_high(cfg.act_high),
   .alert_pin(alert_pin), .alert_st(alert_st), .run_cnt(run_cnt),
   .run_done(run_done), .cfg_wr(cfg_wr), .conv_rd(conv_rd)
);

// File: tb/alert_thresh_comparator_test.sv
module alert_thresh_comparator_test;
   localparam int RB = 12;
   logic clk = 0, rst_n = 0;
   logic [7:0] reg_addr = 0;
   logic reg_wr = 0, reg_rd = 0, res_valid = 0;
   logic [15:0] reg_wdata = 0;
   logic [15:0] reg_rdata;
   logic [RB-1:0] res_data = 0;
   logic alert_pin;

   int n_chk = 0, n_fail = 0;
   bit done = 0;

   logic [15:0] m_cfg = 16'h0003, m_lo = 16'h8000, m_hi = 16'h7FF0, m_conv = 0;
   int m_cnt = 0;
   bit m_st = 0;

   always #2 clk = ~clk;

   alert_thresh_comparator #(.RES_BITS(RB), .ADDR_W(8)) uut (
      .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
      .reg_wdata(reg_wdata), .reg_rd(reg_rd), .reg_rdata(reg_rdata),
      .res_valid(res_valid), .res_data(res_data), .alert_pin(alert_pin));

   task automatic chk(input logic [15:0] act, input logic [15:0] exp, input string tag);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   function automatic logic [15:0] mread(input logic [7:0] a);
      case (a)
         8'd0: return m_conv;
         8'd1: return m_cfg;
         8'd2: return m_lo;
         8'd3: return m_hi;
         default: return 16'h0000;
      endcase
   endfunction

   function automatic logic mpin();
      bit act;
      act = m_st && (m_cfg[1:0] != 2'b11);
      return m_cfg[3] ? act : !act;
   endfunction

   task automatic cyc(input logic [7:0] a, input logic w, input logic [15:0] wd,
                      input logic rd, input logic v, input logic [RB-1:0] d);
      logic signed [15:0] r, slo, shi;
      logic [1:0] q;
      bit lat, win, clr, cfgw, fault, trip, nst;
      int ncnt;
      @(negedge clk);
      reg_addr = a; reg_wr = w; reg_wdata = wd; reg_rd = rd; res_valid = v; res_data = d;
      #1;
      chk(reg_rdata, mread(a), "R1/R3/R4/R13 read data");
      r = {d, 4'b0}; slo = m_lo; shi = m_hi;
      q = m_cfg[1:0]; lat = m_cfg[2]; win = m_cfg[4];
      clr = rd && a == 8'd0; cfgw = w && a == 8'd1;
      ncnt = m_cnt; nst = m_st;
      if (q == 2'b11) begin ncnt = 0; nst = 0; end
      else if (cfgw) begin ncnt = 0; if (lat && clr) nst = 0; end
      else begin
         fault = (r > shi) || (win && r < slo);
         trip = 0;
         if (v) begin
            ncnt = fault ? ((m_cnt == 4) ? 4 : m_cnt + 1) : 0;
            trip = fault && (ncnt >= (1 << q));
         end
         if (trip) nst = 1;
         else if (lat) begin if (clr) nst = 0; end
         else if (v && (win ? !fault : (r <= slo))) nst = 0;
      end
      @(posedge clk); #1;
      m_cnt = ncnt; m_st = nst;
      if (cfgw) m_cfg = wd;
      if (w && a == 8'd2) m_lo = wd & 16'hFFF0;
      if (w && a == 8'd3) m_hi = wd & 16'hFFF0;
      if (v) m_conv = {d, 4'b0};
      reg_wr = 0; reg_rd = 0; res_valid = 0;
      chk({15'b0, alert_pin}, {15'b0, mpin()}, "R5/R8/R9/R10/R12 alert pin");
   endtask

   task automatic peek(input logic [7:0] a, input logic [15:0] exp, input string tag);
      @(negedge clk); reg_addr = a; #1; chk(reg_rdata, exp, tag);
   endtask

   task automatic pin_is(input logic exp, input string tag);
      chk({15'b0, alert_pin}, {15'b0, exp}, tag);
   endtask

   initial begin
      #(200000 * 4);
      if (!done) begin
         done = 1; n_fail++; n_chk++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      int seed;
      seed = 1234;
      void'($urandom(seed));
      repeat (3) @(posedge clk);
      #1 rst_n = 1;
      // R2 reset state
      peek(0, 16'h0000, "R2 conv reset");
      peek(1, 16'h0003, "R2 cfg reset");
      peek(2, 16'h8000, "R2 low reset");
      peek(3, 16'h7FF0, "R2 high reset");
      pin_is(1'b1, "R2/R12 pin inactive high");
      // traditional, queue 4, active-low, transparent
      cyc(1, 1, 16'h0002, 0, 0, 0);
      cyc(3, 1, 16'h1000, 0, 0, 0);
      cyc(2, 1, 16'h0800, 0, 0, 0);
      repeat (3) cyc(0, 0, 0, 0, 1, 12'h200);
      pin_is(1'b1, "R5 three faults not enough");
      cyc(0, 0, 0, 0, 1, 12'h200);
      pin_is(1'b0, "R5 fourth fault asserts (active-low)");
      cyc(0, 0, 0, 0, 1, 12'h0C0);
      pin_is(1'b0, "R8 hysteresis holds between thresholds");
      cyc(0, 0, 0, 0, 1, 12'h080);
      pin_is(1'b1, "R8 release at low threshold");
      // window, latched, active-high, queue 0, spare bits set
      cyc(1, 1, 16'hF01C, 0, 0, 0);
      peek(1, 16'hF01C, "R13 spare bits read back");
      cyc(0, 0, 0, 0, 1, 12'hF00);
      pin_is(1'b1, "R9 below low trips in window mode");
      cyc(0, 0, 0, 0, 1, 12'h0C0);
      pin_is(1'b1, "R10 latched alert holds on in-range result");
      cyc(0, 0, 0, 1, 0, 0);
      pin_is(1'b0, "R10 conversion read clears latch");
      cyc(0, 0, 0, 1, 1, 12'h7FF);
      pin_is(1'b1, "R11 trip wins over clearing read");
      cyc(1, 1, 16'hF01F, 0, 0, 0);
      pin_is(1'b0, "R6 queue code 3 forces inactive");
      cyc(0, 1, 16'h1234, 0, 0, 0);
      peek(0, 16'h7FF0, "R1 write to conversion ignored");
      cyc(8'd5, 1, 16'hBEEF, 0, 0, 0);
      peek(8'd5, 16'h0000, "R1 unmapped address reads zero");
      cyc(2, 1, 16'h1237, 0, 0, 0);
      peek(2, 16'h1230, "R4 threshold low bits masked");
      // traditional, queue 2 faults, active-high, transparent
      cyc(1, 1, 16'h0009, 0, 0, 0);
      cyc(0, 0, 0, 0, 1, 12'h200);
      cyc(0, 0, 0, 0, 1, 12'h0C0);
      cyc(0, 0, 0, 0, 1, 12'h200);
      pin_is(1'b0, "R7 in-range result resets run");
      cyc(1, 1, 16'h0009, 0, 1, 12'h200);
      cyc(0, 0, 0, 0, 1, 12'h200);
      pin_is(1'b0, "R7 config write resets run");
      cyc(0, 0, 0, 0, 1, 12'h200);
      pin_is(1'b1, "R7 run completes after write");
      // random phase
      for (int i = 0; i < 4000; i++) begin
         int k;
         logic [15:0] wd;
         k = $urandom_range(0, 19);
         wd = 16'($urandom);
         if (k < 11)       cyc(8'($urandom_range(0, 3)), 0, 0, 0, 1, 12'($urandom));
         else if (k < 13)  cyc(1, 1, wd, 0, $urandom_range(0, 1) == 1, 12'($urandom));
         else if (k < 15)  cyc(8'($urandom_range(2, 3)), 1, wd, 0, 0, 0);
         else if (k < 18)  cyc(0, 0, 0, 1, $urandom_range(0, 1) == 1, 12'($urandom));
         else              cyc(8'($urandom), $urandom_range(0, 1) == 1, wd, 0, 0, 0);
      end
      if (!done) begin
         done = 1;
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end
endmodule